// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two W-bit operands over W clock cycles using a single W-bit adder. A one-cycle `start` pulse loads the operands. From then on, each cycle looks at the lowest bit of a combined 2W-bit working register. When that bit is set, the adder adds the stationary multiplicand into the upper half of the register. The whole register, together with the adder's carry, then moves right by one place. The upper half of the register holds the growing partial product, and the lower half holds the multiplier bits that have not been used yet.

A mode input selects unsigned or two's-complement operation. In signed mode the operands are first reduced to their magnitudes. The unsigned product of the magnitudes is negated on the way out when exactly one operand was negative. The 2W-bit result appears as an upper and a lower word, and a one-cycle `done` pulse marks when it is ready. The block accepts a new request whenever it is idle; a `start` that arrives while it is working has no effect.

Top module: `mul_seq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `prod_hi` and `prod_lo` are zero and `done` is low.
- R2: With `signed_mode` = 0, {`prod_hi`,`prod_lo`} equals the full 2W-bit unsigned product of `op_a` and `op_b`. No carry is lost, so all-ones times all-ones is exact.
- R3: With `signed_mode` = 1, both operands are read as two's complement and {`prod_hi`,`prod_lo`} is the 2W-bit two's-complement product. It is negative exactly when one operand is negative and the other is nonzero.
- R4: In signed mode, an operand equal to the most negative W-bit value gives the correct product. This holds both when it is multiplied by itself and when it is multiplied by positive values.
- R5: A `start` sampled high at a rising edge while the block is idle is accepted. `done` then rises right after the W-th rising edge that follows the accepting edge, and no earlier.
- R6: `done` is high for exactly one cycle per accepted operation.
- R7: A `start` sampled while an operation is in progress is ignored. The running operation keeps its operands, its result and its `done` timing.
- R8: From the `done` cycle until the next accepted `start`, {`prod_hi`,`prod_lo`} stays constant, whatever the operand and mode inputs do.
- R9: `op_a`, `op_b` and `signed_mode` are sampled only at the accepting edge. Changing them during an operation does not affect its result.
- R10: A zero operand gives a zero product in both modes, including zero times a negative value in signed mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; accepted only while idle |
| op_a | input | W | Multiplicand operand |
| op_b | input | W | Multiplier operand |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| prod_hi | output | W | Upper W bits of the product |
| prod_lo | output | W | Lower W bits of the product |
| done | output | 1 | One-cycle pulse when the product is valid |

## Verification
The bench builds the block with W = 8, so one operation takes eight cycles. At that width every extreme operand can be used directly and its product can be worked out by hand: all-ones, the most negative value, zero and mixed signs. The same width lets the bench watch every cycle of a run. It can therefore confirm that `done` does not arrive early, and it can place a restart request or an operand change at a known step in the middle of an operation.

// File: rtl/mul_seq_pkg.sv
package mul_seq_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_e;
endpackage

// File: rtl/mul_mag_unit.sv
// Turns an operand into its unsigned magnitude when signed handling is on.
module mul_mag_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_in,
    input  logic         sgn_en,
    output logic [W-1:0] mag_out,
    output logic         is_neg
);
    always_comb begin
        is_neg  = sgn_en & val_in[W-1];
        // The most negative value maps onto itself, which is its correct unsigned magnitude
        mag_out = is_neg ? (~val_in + W'(1)) : val_in;
    end
endmodule

// File: rtl/mul_step_add.sv
// The single W-bit adder with its carry out kept as an extra bit.
module mul_step_add #(
    parameter int W = 32
) (
    input  logic [W-1:0] upper_in,
    input  logic [W-1:0] mcand_in,
    input  logic         add_en,
    output logic [W:0]   sum_out
);
    always_comb begin
        sum_out = {1'b0, upper_in} + {1'b0, (add_en ? mcand_in : '0)};
    end
endmodule

// File: rtl/mul_sign_fix.sv
// Applies the final sign to the 2W-bit magnitude product.
module mul_sign_fix #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] raw_in,
    input  logic           neg_in,
    output logic [2*W-1:0] res_out
);
    localparam int PW = 2 * W;

    always_comb begin
        res_out = neg_in ? (~raw_in + PW'(1)) : raw_in;
    end
endmodule

// File: rtl/mul_core.sv
// Step engine: stationary multiplicand, shared product/multiplier register.
module mul_core
    import mul_seq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    input  logic           neg_in,
    output logic [2*W-1:0] acc_out,
    output logic           neg_out,
    output logic           done
);
    localparam int PW = 2 * W;
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    typedef struct packed {
        mul_state_e     state;
        logic [W-1:0]   mcand;
        logic [PW-1:0]  acc;
        logic [CW-1:0]  step;
        logic           neg;
        logic           done;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [W:0] sum_w;

    mul_step_add #(.W(W)) u_add (
        .upper_in (st_q.acc[PW-1:W]),
        .mcand_in (st_q.mcand),
        .add_en   (st_q.acc[0]),
        .sum_out  (sum_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.state = ST_RUN;
                    st_d.mcand = mcand_in;
                    st_d.acc   = {{W{1'b0}}, mplier_in};
                    st_d.neg   = neg_in;
                    st_d.step  = '0;
                end
            end
            default: begin
                // Carry enters the top bit; the used multiplier bit falls off the bottom
                st_d.acc = {sum_w, st_q.acc[W-1:1]};
                if (st_q.step == LAST_STEP) begin
                    st_d.state = ST_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.step = st_q.step + CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, mcand: '0, acc: '0, step: '0, neg: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out = st_q.acc;
    assign neg_out = st_q.neg;
    assign done    = st_q.done;
endmodule

// File: rtl/mul_seq_top.sv
module mul_seq_top #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         signed_mode,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo,
    output logic         done
);
    localparam int PW = 2 * W;
    localparam int NOPS = 2;

    logic [W-1:0]  ops_w  [NOPS];
    logic [W-1:0]  mags_w [NOPS];
    logic [NOPS-1:0] negs_w;
    logic [PW-1:0] acc_w;
    logic [PW-1:0] res_w;
    logic          neg_w;

    assign ops_w[0] = op_a;
    assign ops_w[1] = op_b;

    for (genvar g = 0; g < NOPS; g++) begin : g_mag
        mul_mag_unit #(.W(W)) u_mag (
            .val_in  (ops_w[g]),
            .sgn_en  (signed_mode),
            .mag_out (mags_w[g]),
            .is_neg  (negs_w[g])
        );
    end

    mul_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mcand_in  (mags_w[0]),
        .mplier_in (mags_w[1]),
        .neg_in    (^negs_w),
        .acc_out   (acc_w),
        .neg_out   (neg_w),
        .done      (done)
    );

    mul_sign_fix #(.W(W)) u_fix (
        .raw_in  (acc_w),
        .neg_in  (neg_w),
        .res_out (res_w)
    );

    assign prod_hi = res_w[PW-1:W];
    assign prod_lo = res_w[W-1:0];
endmodule

// File: rtl/mul_seq_chk.sv
// Port-level protocol checker, attached to the top by bind.
module mul_seq_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] prod_hi,
    input logic [W-1:0] prod_lo,
    input logic         done
);
    localparam int CW = $clog2(W + 1) + 1;
    localparam logic [CW-1:0] DUE = CW'(W);

    logic          bsy_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bsy_q <= 1'b0;
            cnt_q <= '0;
        end else if (start && (!bsy_q || done)) begin
            bsy_q <= 1'b1;
            cnt_q <= '0;
        end else if (done) begin
            bsy_q <= 1'b0;
        end else if (bsy_q) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R5
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bsy_q && cnt_q == DUE));

    // R7
    done_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy_q && cnt_q == DUE) |-> done);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bsy_q && !start) |=> $stable({prod_hi, prod_lo}));
endmodule

bind mul_seq_top mul_seq_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .prod_hi (prod_hi),
    .prod_lo (prod_lo),
    .done    (done)
);

// File: tb/sim_mul_seq_top.sv
`timescale 1ns/1ps
module sim_mul_seq_top;
    localparam int W  = 8;
    localparam int NV = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] prod_hi, prod_lo;
    logic         done;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    mul_seq_top #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .signed_mode(signed_mode), .prod_hi(prod_hi), .prod_lo(prod_lo), .done(done)
    );

    // {signed, a, b, expected product}
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'd8,   8'd9,   16'h0048},  // R2 8*9
        {1'b0, 8'hFF,  8'hFF,  16'hFE01},  // R2 carry kept
        {1'b0, 8'h00,  8'd200, 16'h0000},  // R10
        {1'b0, 8'h80,  8'h02,  16'h0100},  // R2
        {1'b1, 8'hFD,  8'h05,  16'hFFF1},  // R3 -3*5
        {1'b1, 8'hF9,  8'hFA,  16'h002A},  // R3 -7*-6
        {1'b1, 8'h7F,  8'hFF,  16'hFF81},  // R3 127*-1
        {1'b1, 8'h80,  8'h80,  16'h4000},  // R4 min*min
        {1'b1, 8'h80,  8'h7F,  16'hC080},  // R4 min*127
        {1'b1, 8'h00,  8'hFB,  16'h0000},  // R10 0*-5
        {1'b0, 8'hFD,  8'h05,  16'h04F1},  // R2 253*5
        {1'b1, 8'h01,  8'h80,  16'hFF80}   // R4 1*min
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one operation; optional mid-run operand change and restart request.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                          input bit disturb, input bit restart,
                          output logic [2*W-1:0] prod, output bit t_ok, output bit p_ok);
        @(negedge clk);
        op_a = a; op_b = b; signed_mode = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t_ok = !done;
        prod = '0;
        for (int i = 1; i <= W; i++) begin
            if (disturb && i == 2) begin
                op_a = ~a; op_b = a ^ 8'h5A; signed_mode = ~s;
            end
            if (restart && i == 3) begin
                op_a = 8'h03; op_b = 8'h03; start = 1'b1;
            end
            if (restart && i == 4) start = 1'b0;
            @(negedge clk);
            if (i < W && done) t_ok = 1'b0;
            if (i == W) begin
                if (!done) t_ok = 1'b0;
                prod = {prod_hi, prod_lo};
            end
        end
        @(negedge clk);
        p_ok = !done;
    endtask

    initial begin
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [2*W-1:0] p;
        logic [2*W-1:0] held;
        bit t_ok, p_ok;

        repeat (3) @(negedge clk);
        // R1 during reset
        check(prod_hi == 0 && prod_lo == 0 && !done, "R1 in reset", {prod_hi, prod_lo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(prod_hi == 0 && prod_lo == 0 && !done, "R1 after reset", {prod_hi, prod_lo}, 0);

        for (int k = 0; k < NV; k++) begin
            run_op(VEC[k][31:24], VEC[k][23:16], VEC[k][32], 1'b0, 1'b0, p, t_ok, p_ok);
            check(p == VEC[k][15:0], "R2/R3/R4/R10 product", p, VEC[k][15:0]);
            check(t_ok, "R5 done timing", 32'(t_ok), 1);
            check(p_ok, "R6 done one cycle", 32'(p_ok), 1);
        end

        // R8 hold: inputs wiggle without start
        held = {prod_hi, prod_lo};
        for (int j = 0; j < 5; j++) begin
            op_a = 8'(j * 37); op_b = 8'(j * 11 + 1); signed_mode = j[0];
            @(negedge clk);
            check({prod_hi, prod_lo} == held && !done, "R8 hold", {prod_hi, prod_lo}, held);
        end

        // R9 operands changed mid-run: -6*7 = -42
        run_op(8'hFA, 8'h07, 1'b1, 1'b1, 1'b0, p, t_ok, p_ok);
        check(p == 16'hFFD6, "R9 mid-run change", p, 16'hFFD6);
        check(t_ok, "R9 timing", 32'(t_ok), 1);

        // R7 restart request while busy: 25*10 = 250
        run_op(8'd25, 8'd10, 1'b0, 1'b0, 1'b1, p, t_ok, p_ok);
        check(p == 16'h00FA, "R7 restart ignored product", p, 16'h00FA);
        check(t_ok, "R7 restart ignored timing", 32'(t_ok), 1);
        check(p_ok, "R7 single done", 32'(p_ok), 1);
        repeat (W + 2) begin
            @(negedge clk);
            check(!done, "R7 no extra done", 32'(done), 0);
        end

        // R3 back-to-back sign change: -1*-1 = 1
        run_op(8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0, p, t_ok, p_ok);
        check(p == 16'h0001, "R3 -1*-1", p, 16'h0001);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule